// File: doc/BRIEF.md
# Programmable master sync generator

This block produces the horizontal and vertical sync pulses for a display raster when the chip drives the timing itself. A clock-enable prescaler divides the system clock into a fixed timebase tick of 30 ns, so the line period is set in whole ticks and does not depend on any pixel clock. A 12-bit period value sets the number of ticks per line. A 10-bit value sets the number of lines that make up a frame.

A single mode bit selects the vertical cadence. When the bit is 0, two vertical pulses fall in each frame. One comes at the start of line 0. The other comes half a frame later, and it lands at mid-line when the line count is odd, so 625 lines yield a pulse every 312.5 lines. When the bit is 1, one vertical pulse comes every programmed line count, always at the start of a line. A field flag marks which half of the raster is running.

The three setting inputs are sampled only at frame boundaries, so changes made mid-frame never tear the raster. Out-of-range settings are raised to safe minimums so that the counters cannot stall.

Top module: `msync_gen`

## Requirements
- R1: Raster counters advance only on a timebase tick, which occurs once every TICK_DIV clock cycles. Every output transition follows a tick edge. The first vertical pulse, with hsync also high, appears on the TICK_DIV-th clock edge after reset is released.
- R2: Consecutive hsync rising edges are exactly HP ticks apart (HP × TICK_DIV clock cycles), where HP is the effective period value.
- R3: Each hsync pulse stays high for HS_W ticks.
- R4: With the mode bit at 0 and N effective lines, a frame-start vsync pulse begins at the start of line 0. A second pulse begins floor(N/2) lines plus floor(HP/2) ticks later when N is odd, or N/2 lines later when N is even. The next frame start follows after the remainder of the N × HP tick frame.
- R5: With the mode bit at 1, vsync rising edges are exactly N × HP ticks apart, and each one coincides with an hsync rising edge (no half-line offset).
- R6: Each vsync pulse stays high for VS_W ticks.
- R7: With the mode bit at 0, field is 0 after a frame-start pulse and 1 after a half-frame pulse. With the mode bit at 1, field inverts at every vsync pulse. Field changes only at the start of a vsync pulse.
- R8: The period, line-count and mode inputs are captured only on the first tick after reset and at the tick that ends the last line of a frame. A change made mid-frame leaves the current frame's timing untouched and governs the next frame.
- R9: A period value below HS_W+1 is used as HS_W+1. A line count below 2 is used as 2.
- R10: While reset is asserted, hsync, vsync and field are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hper_i | input | 12 | Line period in timebase ticks |
| lines_i | input | 10 | Lines per frame |
| whole_frame_i | input | 1 | 1: one vsync per line count; 0: two vsyncs per frame on half-frame points |
| hsync_o | output | 1 | Horizontal sync pulse, active high |
| vsync_o | output | 1 | Vertical sync pulse, active high |
| field_o | output | 1 | Field flag |

## Verification
The bench builds the block with TICK_DIV = 3, HS_W = 4 and VS_W = 6. Together with periods of about 20 ticks and frames of 5 to 8 lines, this puts a whole frame within a few hundred cycles. The reset values would need over a million ticks per frame. The odd period of 21 ticks makes the two half-frame intervals of an odd-line frame differ by one tick, so an off-by-one in the mid-line point shows up directly. The small widths also let the clamped period (HS_W+1) and the two-line floor be measured in full.

// File: rtl/msync_pkg.sv
package msync_pkg;
    localparam int HP_W = 12;
    localparam int VL_W = 10;

    localparam logic [HP_W-1:0] HP_RST = 12'h855;
    localparam logic [VL_W-1:0] VL_RST = 10'd625;

    typedef struct packed {
        logic [HP_W-1:0] hp;
        logic [VL_W-1:0] vl;
        logic            whole;
    } cfg_t;

    typedef struct packed {
        logic [HP_W-1:0] h;
        logic [VL_W-1:0] ln;
        cfg_t            cfg;
        logic            run;
    } ras_t;
endpackage

// File: rtl/msync_tick.sv
module msync_tick #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = (st_q.cnt == LAST);
        if (tick_o) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/msync_raster.sv
module msync_raster
    import msync_pkg::*;
#(
    parameter int HS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [HP_W-1:0] hper_i,
    input  logic [VL_W-1:0] lines_i,
    input  logic            whole_i,
    output logic [HP_W-1:0] h_nxt_o,
    output logic            frame_evt_o,
    output logic            mid_evt_o,
    output logic            whole_nxt_o
);
    localparam logic [HP_W-1:0] HP_MIN = HP_W'(HS_W + 1);
    localparam logic [VL_W-1:0] VL_MIN = VL_W'(2);

    ras_t st_d, st_q;
    cfg_t cand;
    logic [VL_W-1:0] mid_ln;
    logic [HP_W-1:0] mid_h;

    always_comb begin
        cand.hp    = (hper_i < HP_MIN) ? HP_MIN : hper_i;
        cand.vl    = (lines_i < VL_MIN) ? VL_MIN : lines_i;
        cand.whole = whole_i;
        mid_ln     = st_q.cfg.vl >> 1;
        mid_h      = st_q.cfg.vl[0] ? (st_q.cfg.hp >> 1) : '0;

        st_d        = st_q;
        frame_evt_o = 1'b0;
        mid_evt_o   = 1'b0;
        if (tick_i) begin
            if (!st_q.run) begin
                st_d.run    = 1'b1;
                st_d.cfg    = cand;
                st_d.h      = '0;
                st_d.ln     = '0;
                frame_evt_o = 1'b1;
            end else if (st_q.h == st_q.cfg.hp - HP_W'(1)) begin
                st_d.h = '0;
                if (st_q.ln == st_q.cfg.vl - VL_W'(1)) begin
                    st_d.ln     = '0;
                    st_d.cfg    = cand;
                    frame_evt_o = 1'b1;
                end else begin
                    st_d.ln = st_q.ln + VL_W'(1);
                end
            end else begin
                st_d.h = st_q.h + HP_W'(1);
            end
            mid_evt_o = st_q.run && !st_q.cfg.whole && !frame_evt_o
                        && (st_d.ln == mid_ln) && (st_d.h == mid_h);
        end
        h_nxt_o     = st_d.h;
        whole_nxt_o = st_d.cfg.whole;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.cfg.hp    <= HP_RST;
            st_q.cfg.vl    <= VL_RST;
            st_q.cfg.whole <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/msync_pulse.sv
module msync_pulse
    import msync_pkg::*;
#(
    parameter int HS_W = 4,
    parameter int VS_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [HP_W-1:0] h_nxt_i,
    input  logic            frame_evt_i,
    input  logic            mid_evt_i,
    input  logic            whole_nxt_i,
    output logic            hsync_o,
    output logic            vsync_o,
    output logic            field_o
);
    localparam int VW = $clog2(VS_W + 1);

    typedef struct packed {
        logic          hs;
        logic          vs;
        logic [VW-1:0] vcnt;
        logic          fld;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.hs = (int'(h_nxt_i) < HS_W);
            if (st_q.vcnt != '0) st_d.vcnt = st_q.vcnt - VW'(1);
            if (frame_evt_i || mid_evt_i) st_d.vcnt = VW'(VS_W);
            if (frame_evt_i) st_d.fld = whole_nxt_i ? ~st_q.fld : 1'b0;
            if (mid_evt_i)   st_d.fld = 1'b1;
            st_d.vs = (st_d.vcnt != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hsync_o = st_q.hs;
    assign vsync_o = st_q.vs;
    assign field_o = st_q.fld;
endmodule

// File: rtl/msync_gen.sv
module msync_gen
    import msync_pkg::*;
#(
    parameter int TICK_DIV = 3,
    parameter int HS_W     = 157,
    parameter int VS_W     = 5332
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HP_W-1:0] hper_i,
    input  logic [VL_W-1:0] lines_i,
    input  logic            whole_frame_i,
    output logic            hsync_o,
    output logic            vsync_o,
    output logic            field_o
);
    logic            tick_w;
    logic [HP_W-1:0] h_nxt_w;
    logic            frame_evt_w;
    logic            mid_evt_w;
    logic            whole_nxt_w;

    msync_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    msync_raster #(.HS_W(HS_W)) u_raster (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_w),
        .hper_i      (hper_i),
        .lines_i     (lines_i),
        .whole_i     (whole_frame_i),
        .h_nxt_o     (h_nxt_w),
        .frame_evt_o (frame_evt_w),
        .mid_evt_o   (mid_evt_w),
        .whole_nxt_o (whole_nxt_w)
    );

    msync_pulse #(.HS_W(HS_W), .VS_W(VS_W)) u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_w),
        .h_nxt_i     (h_nxt_w),
        .frame_evt_i (frame_evt_w),
        .mid_evt_i   (mid_evt_w),
        .whole_nxt_i (whole_nxt_w),
        .hsync_o     (hsync_o),
        .vsync_o     (vsync_o),
        .field_o     (field_o)
    );
endmodule

// File: rtl/msync_gen_chk.sv
module msync_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic frame_evt,
    input logic mid_evt,
    input logic hsync_o,
    input logic vsync_o,
    input logic field_o
);
    p_hs_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hsync_o) |-> $past(tick));

    p_vs_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vsync_o) |-> $past(tick));

    p_evt_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_evt && mid_evt));

    p_vs_after_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_evt || mid_evt) |=> vsync_o);

    p_field_at_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_o) |-> $past(frame_evt || mid_evt));
endmodule

bind msync_gen msync_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_w),
    .frame_evt (frame_evt_w),
    .mid_evt   (mid_evt_w),
    .hsync_o   (hsync_o),
    .vsync_o   (vsync_o),
    .field_o   (field_o)
);

// File: tb/msync_gen_tb.sv
module msync_gen_tb_top;
    localparam int D   = 3;
    localparam int HSW = 4;
    localparam int VSW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] hper = 12'd21;
    logic [9:0]  lines = 10'd7;
    logic        whole = 1'b0;
    logic        hsync, vsync, field;

    longint cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    msync_gen #(.TICK_DIV(D), .HS_W(HSW), .VS_W(VSW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .hper_i        (hper),
        .lines_i       (lines),
        .whole_frame_i (whole),
        .hsync_o       (hsync),
        .vsync_o       (vsync),
        .field_o       (field)
    );

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rise_hs(output longint t);
        while (hsync) @(negedge clk);
        while (!hsync) @(negedge clk);
        t = cyc;
    endtask

    task automatic rise_vs(output longint t);
        while (vsync) @(negedge clk);
        while (!vsync) @(negedge clk);
        t = cyc;
    endtask

    task automatic frame_start(output longint t);
        rise_vs(t);
        while (field) rise_vs(t);
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 hsync in reset", hsync, 0);
        chk("R10 vsync in reset", vsync, 0);
        chk("R10 field in reset", field, 0);
        rst_n = 1'b1;
        n = 0;
        while (!vsync && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk("R1 first pulse edge", n, D);
        chk("R1 hsync at first pulse", hsync, 1);
        chk("R7 field at first frame start", field, 0);
    endtask

    task automatic t_interlace_odd();
        longint t0, t1, t2, h1, h2;
        int w;
        t0 = cyc;
        rise_vs(t1);
        chk("R4 odd start->mid", t1 - t0, (3 * 21 + 10) * D);
        chk("R7 field after mid", field, 1);
        w = 0;
        while (vsync) begin
            @(negedge clk);
            w++;
        end
        chk("R6 vsync width", w, VSW * D);
        rise_vs(t2);
        chk("R4 odd mid->start", t2 - t1, (7 * 21 - 73) * D);
        chk("R7 field after start", field, 0);
        rise_hs(h1);
        w = 0;
        while (hsync) begin
            @(negedge clk);
            w++;
        end
        chk("R3 hsync width", w, HSW * D);
        rise_hs(h2);
        chk("R2 hsync period", h2 - h1, 21 * D);
    endtask

    task automatic t_interlace_even();
        longint t0, t1, t2;
        lines = 10'd8;
        frame_start(t0);
        rise_vs(t1);
        chk("R4 even start->mid", t1 - t0, 4 * 21 * D);
        rise_vs(t2);
        chk("R4 even mid->start", t2 - t1, 4 * 21 * D);
    endtask

    task automatic t_update();
        longint tp, tf, th, tn;
        frame_start(tp);
        rise_hs(th);
        rise_hs(th);
        @(negedge clk);
        hper = 12'd30;
        frame_start(tf);
        chk("R8 current frame kept old period", tf - tp, 8 * 21 * D);
        rise_hs(tn);
        chk("R8 new period after boundary", tn - tf, 30 * D);
    endtask

    task automatic t_progressive();
        longint t0, t1, t2;
        logic f0;
        whole = 1'b1;
        hper  = 12'd21;
        lines = 10'd5;
        frame_start(t0);
        f0 = field;
        rise_vs(t1);
        chk("R5 whole-count vsync period", t1 - t0, 5 * 21 * D);
        chk("R5 hsync rises with vsync", hsync, 1);
        chk("R7 field toggles", field, !f0);
        rise_vs(t2);
        chk("R5 whole-count vsync period 2", t2 - t1, 5 * 21 * D);
        chk("R7 field toggles back", field, f0);
    endtask

    task automatic t_clamp();
        longint t0, t1, h1, h2;
        hper  = 12'd0;
        lines = 10'd1;
        rise_vs(t0);
        rise_vs(t0);
        rise_vs(t1);
        chk("R9 clamped frame", t1 - t0, 2 * (HSW + 1) * D);
        rise_hs(h1);
        rise_hs(h2);
        chk("R9 clamped period", h2 - h1, (HSW + 1) * D);
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_interlace_odd();
        t_interlace_even();
        t_update();
        t_progressive();
        t_clamp();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule